// File: doc/BRIEF.md
# Set/Clear Control Flag Bank

This block keeps a small group of control flags that a bus slave updates without read-modify-write. Each flag owns two positions in the 32-bit write word, sixteen bits apart: a 1 in the low-half position turns the flag on, and a 1 in the matching high-half position turns it off. A 0 in either position leaves the flag as it is. A single write can therefore change any subset of the flags and leave the others alone.

The bank has three registers, each with its own write strobe from the address decoder outside the block. The first is a five-flag simulation-mode register. The second is a single software-reset flag. The third is a two-line control register. Only the control register can be read back, through a data bus that always shows its current state. The flags update on the clock edge where their strobe is high. If a write carries both the set and the clear position for a flag, the clear takes effect.

Top module: `sc_ctrl_bank`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `mode_flags`, `soft_rst` and `ctrl_lines` are all 0. A reset in mid-run clears flags that were set.
- R2: A clock edge with `wr_mode` high and `wr_data[n]` = 1 (n = 0..4) sets `mode_flags[n]`, as seen after that edge.
- R3: A clock edge with `wr_mode` high and `wr_data[n+16]` = 1 (n = 0..4) clears `mode_flags[n]`.
- R4: A strobed write with 0 in both the set and the clear position of a flag leaves that flag unchanged.
- R5: When the set and the clear position of a flag are both 1 in the same strobed write, the flag becomes 0.
- R6: With `wr_srst` high, `wr_data[0]` sets `soft_rst` and `wr_data[16]` clears it.
- R7: With `wr_ctrl` high, `wr_data[1:0]` set `ctrl_lines[1:0]` and `wr_data[17:16]` clear them.
- R8: `rd_data[1:0]` always equals `ctrl_lines`, and `rd_data[31:2]` is always 0.
- R9: A register whose strobe is low keeps its flags, whatever the data bus and the other strobes carry.
- R10: Data bits outside a register's set and clear positions have no effect. These are bits 5-15 and 21-31 for the mode register, 1-15 and 17-31 for the soft reset, and 2-15 and 18-31 for the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hardware reset |
| wr_data | input | 32 | Write word: set positions in the low half, clear positions in the high half |
| wr_mode | input | 1 | Write strobe for the simulation-mode register |
| wr_srst | input | 1 | Write strobe for the software-reset register |
| wr_ctrl | input | 1 | Write strobe for the control-line register |
| mode_flags | output | 5 | Simulation-mode flags |
| soft_rst | output | 1 | Software reset flag |
| ctrl_lines | output | 2 | Control-line flags |
| rd_data | output | 32 | Read-back word of the control-line register |

## Verification
The bench drives set-only, clear-only, set-and-clear and all-zero words through each strobe. These show whether a flag reacts to the correct half and whether the clear takes priority. Words with every unrelated bit set, and writes with the strobe low, show that no stray bit or unselected register leaks into the flags. A pseudorandom stretch with several strobes active at once, followed by a reset in mid-run, tests that the registers stay independent and that all of them clear together.

// File: rtl/sc_bank_pkg.sv
package sc_bank_pkg;
    localparam int DATA_W = 32;
    localparam int MODE_W = 5;
    localparam int SRST_W = 1;
    localparam int CTRL_W = 2;
endpackage

// File: rtl/sc_flag_reg.sv
module sc_flag_reg #(
    parameter int W  = 2,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] data,
    output logic [W-1:0]  q
);
    localparam int CLR_OFS = DW / 2;

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic set_b;
        logic clr_b;
        assign set_b = data[b];
        assign clr_b = data[b + CLR_OFS];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[b] <= 1'b0;
            end else if (we) begin
                if (clr_b) begin
                    q[b] <= 1'b0;
                end else if (set_b) begin
                    q[b] <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sc_readback.sv
module sc_readback #(
    parameter int W  = 2,
    parameter int DW = 32
) (
    input  logic [W-1:0]  flags,
    output logic [DW-1:0] rd
);
    always_comb begin
        rd        = '0;
        rd[W-1:0] = flags;
    end
endmodule

// File: rtl/sc_ctrl_bank.sv
module sc_ctrl_bank
    import sc_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_mode,
    input  logic              wr_srst,
    input  logic              wr_ctrl,
    output logic [MODE_W-1:0] mode_flags,
    output logic              soft_rst,
    output logic [CTRL_W-1:0] ctrl_lines,
    output logic [DATA_W-1:0] rd_data
);
    logic [SRST_W-1:0] srst_q;

    sc_flag_reg #(.W(MODE_W), .DW(DATA_W)) u_mode (
        .clk(clk), .rst_n(rst_n), .we(wr_mode), .data(wr_data), .q(mode_flags)
    );

    sc_flag_reg #(.W(SRST_W), .DW(DATA_W)) u_srst (
        .clk(clk), .rst_n(rst_n), .we(wr_srst), .data(wr_data), .q(srst_q)
    );

    sc_flag_reg #(.W(CTRL_W), .DW(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .we(wr_ctrl), .data(wr_data), .q(ctrl_lines)
    );

    sc_readback #(.W(CTRL_W), .DW(DATA_W)) u_rd (
        .flags(ctrl_lines), .rd(rd_data)
    );

    assign soft_rst = srst_q[0];
endmodule

// File: rtl/sc_ctrl_bank_chk.sv
module sc_ctrl_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] wr_data,
    input logic        wr_mode,
    input logic        wr_srst,
    input logic        wr_ctrl,
    input logic [4:0]  mode_flags,
    input logic        soft_rst,
    input logic [1:0]  ctrl_lines,
    input logic [31:0] rd_data
);
    // R2
    mode_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode && wr_data[0] && !wr_data[16] |=> mode_flags[0]);
    // R5
    mode_clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode && wr_data[20] |=> !mode_flags[4]);
    // R6
    srst_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_srst && wr_data[0] && !wr_data[16] |=> soft_rst);
    // R6
    srst_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_srst && wr_data[16] |=> !soft_rst);
    // R7
    ctrl_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl && wr_data[17] |=> !ctrl_lines[1]);
    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mode |=> $stable(mode_flags));
    // R9
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(ctrl_lines));
    // R8
    rd_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[31:2] == 30'd0 && rd_data[1:0] == ctrl_lines);
endmodule

bind sc_ctrl_bank sc_ctrl_bank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_mode(wr_mode),
    .wr_srst(wr_srst), .wr_ctrl(wr_ctrl), .mode_flags(mode_flags),
    .soft_rst(soft_rst), .ctrl_lines(ctrl_lines), .rd_data(rd_data)
);

// File: tb/tb_sc_ctrl_bank.sv
module tb_sc_ctrl_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_mode = 1'b0;
    logic        wr_srst = 1'b0;
    logic        wr_ctrl = 1'b0;
    logic [4:0]  mode_flags;
    logic        soft_rst;
    logic [1:0]  ctrl_lines;
    logic [31:0] rd_data;

    int n_checks = 0;
    int n_errs   = 0;
    int cycles   = 0;
    bit m_mode[5];
    bit m_srst;
    bit m_ctrl[2];

    sc_ctrl_bank dut (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_mode(wr_mode),
        .wr_srst(wr_srst), .wr_ctrl(wr_ctrl), .mode_flags(mode_flags),
        .soft_rst(soft_rst), .ctrl_lines(ctrl_lines), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    function automatic void summary_and_end();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            n_errs++;
            n_checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<=5000", cycles);
            summary_and_end();
        end
    end

    task automatic compare(input string tag);
        logic [4:0]  em;
        logic [1:0]  ec;
        logic [31:0] er;
        for (int i = 0; i < 5; i++) em[i] = m_mode[i];
        for (int i = 0; i < 2; i++) ec[i] = m_ctrl[i];
        er = 32'(ec);
        n_checks++;
        if (mode_flags !== em || soft_rst !== m_srst || ctrl_lines !== ec) begin
            n_errs++;
            $display("FAIL %s: actual mode=%b srst=%b ctrl=%b expected mode=%b srst=%b ctrl=%b",
                     tag, mode_flags, soft_rst, ctrl_lines, em, m_srst, ec);
        end
        n_checks++;
        if (rd_data !== er) begin
            n_errs++;
            $display("FAIL R8 (%s): actual rd_data=%h expected %h", tag, rd_data, er);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 5; i++) m_mode[i] = 1'b0;
        for (int i = 0; i < 2; i++) m_ctrl[i] = 1'b0;
        m_srst = 1'b0;
    endtask

    // Drive at negedge, model the edge, compare at the next negedge.
    task automatic step(input string tag, input logic [31:0] d,
                        input logic sm, input logic ss, input logic sc);
        wr_data = d; wr_mode = sm; wr_srst = ss; wr_ctrl = sc;
        if (sm) for (int i = 0; i < 5; i++) begin
            if (d[i+16]) m_mode[i] = 1'b0;
            else if (d[i]) m_mode[i] = 1'b1;
        end
        if (ss) begin
            if (d[16]) m_srst = 1'b0;
            else if (d[0]) m_srst = 1'b1;
        end
        if (sc) for (int i = 0; i < 2; i++) begin
            if (d[i+16]) m_ctrl[i] = 1'b0;
            else if (d[i]) m_ctrl[i] = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        wr_mode = 0; wr_srst = 0; wr_ctrl = 0;
        compare(tag);
    endtask

    initial begin
        model_reset();
        @(negedge clk);
        @(negedge clk);
        compare("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after release");

        step("R2 set 0x15", 32'h0000_0015, 1, 0, 0);
        step("R2 set 0x0A", 32'h0000_000A, 1, 0, 0);
        step("R4 zero word", 32'h0000_0000, 1, 0, 0);
        step("R3 clear 0,2", 32'h0005_0000, 1, 0, 0);
        step("R10 mode stray bits", 32'hFFE0_FFE0, 1, 0, 0);
        step("R2 set all", 32'h0000_001F, 1, 0, 0);
        step("R5 mode both", 32'h0011_0011, 1, 0, 0);
        step("R5 mode all both", 32'h001F_001F, 1, 0, 0);
        step("R6 srst set", 32'h0000_0001, 0, 1, 0);
        step("R10 srst stray bits", 32'hFFFE_FFFE, 0, 1, 0);
        step("R6 srst clear", 32'h0001_0000, 0, 1, 0);
        step("R6 srst set again", 32'h0000_0001, 0, 1, 0);
        step("R5 srst both", 32'h0001_0001, 0, 1, 0);
        step("R7 ctrl set", 32'h0000_0003, 0, 0, 1);
        step("R8 readback", 32'h0000_0000, 0, 0, 0);
        step("R7 ctrl clear bit1", 32'h0002_0000, 0, 0, 1);
        step("R10 ctrl stray bits", 32'hFFFC_FFFC, 0, 0, 1);
        step("R9 no strobe", 32'hFFFF_0000, 0, 0, 0);
        step("R9 mode only", 32'h0000_FFFF, 1, 0, 0);
        step("R9 no strobe set", 32'h0000_FFFF, 0, 0, 0);
        for (int k = 0; k < 60; k++) begin
            logic [31:0] r;
            logic [2:0]  s;
            r = $urandom;
            s = 3'($urandom);
            step("R9 random", r, s[0], s[1], s[2]);
        end
        step("R2 set before reset", 32'h0000_001F, 1, 1, 1);
        rst_n = 1'b0;
        model_reset();
        @(negedge clk);
        compare("R1 mid-run reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after mid-run release");
        summary_and_end();
    end
endmodule